// File: doc/BRIEF.md
# Masked Vector Slide Unit

This block holds a small vector register file and moves elements of one register into another by a scalar distance. Four operations are offered: slide toward higher indices, slide toward lower indices, and the two single-step variants that slide by one and insert a scalar value into the element left empty. Element width is 8, 16, 32 or 64 bits. The number of elements per register, VLMAX, is VLEN divided by the element width.

A command carries the operation, the destination and source register numbers, a 64-bit offset, a 64-bit scalar, the mask-enable bit, the first element to process (vstart) and the active length (vl). An immediate offset is zero-extended onto the offset port by the issuer. When a command is accepted, the unit captures the low mask bits of register 0 and walks the destination one element per cycle, from index 0 to VLMAX-1. Each element falls into one of three regions: an unchanged prefix, a body where active elements take a source element, and a tail that is zeroed. When the walk ends, `done` pulses. A host port loads and reads whole registers while the unit is idle.

Top module: `slide_unit`

## Requirements
- R1: After reset, `busy`, `done` and `illegal` are 0 and every register reads as zero.
- R2: Slide-up (op code 0): element i with max(vstart, offset) <= i < vl takes source element i-offset when active. Elements below that bound keep their value.
- R3: Element i is active when the mask-enable bit is 1, or when bit i of register 0 is 1, using the value register 0 had when the command was accepted. Inactive body elements keep their value.
- R4: When vl > 0, elements vl through VLMAX-1 are written with zero for every operation.
- R5: The offset is compared at its full 64 bits. An offset of at least vl leaves slide-up with no body. An offset whose low bits are small but whose upper bits are nonzero never behaves like the small value.
- R6: A command with vl = 0 modifies no register. `done` rises in the cycle after acceptance and `busy` stays 0.
- R7: Slide-down (op code 1): an active body element i (vstart <= i < vl) takes source element i+offset when i+offset < VLMAX, and zero otherwise. The sum does not wrap.
- R8: Slide-1-up (op code 2) behaves as slide-up by 1, except that element 0, when active and vstart is 0, takes the low SEW bits of the scalar.
- R9: Slide-1-down (op code 3) behaves as slide-down by 1, except that element vl-1, when active and not below vstart, takes the low SEW bits of the scalar.
- R10: A slide-up or slide-1-up whose destination equals its source is rejected. `illegal` and `done` are both 1 for one cycle after acceptance, and no register changes.
- R11: Element width code 0/1/2/3 selects 8/16/32/64 bits. Element i of a register occupies bits [i*SEW, i*SEW+SEW-1], and VLMAX = VLEN/SEW.
- R12: A command is accepted only while `busy` is 0. A non-empty legal command holds `busy` for VLMAX cycles. `done` is a one-cycle pulse seen VLMAX clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Write a whole register (ignored while busy) |
| host_wreg | input | $clog2(NREG) | Register written by the host |
| host_wdata | input | VLEN | Host write data |
| host_rreg | input | $clog2(NREG) | Register read by the host |
| host_rdata | output | VLEN | Content of the register selected by host_rreg |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 up, 1 down, 2 one-up, 3 one-down |
| cmd_sew | input | 2 | Element width code |
| cmd_vd | input | $clog2(NREG) | Destination register |
| cmd_vs2 | input | $clog2(NREG) | Source register |
| cmd_offset | input | OFFW | Slide distance (ignored by the single-step operations) |
| cmd_scalar | input | 64 | Value inserted by the single-step operations |
| cmd_vm | input | 1 | 1 = all elements active, 0 = register 0 masks |
| cmd_vstart | input | $clog2(VLEN/8+1) | First element processed |
| cmd_vl | input | $clog2(VLEN/8+1) | Active length (values above VLMAX are clamped) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse with done for a rejected command |

## Verification
A wrong region boundary shows up in the destination register as soon as `done` pulses. Depending on the fault, the prefix has been overwritten, a masked element has changed, or a tail element is nonzero. These faults are caught by comparing every register against a bench model after each command. A truncated offset compare shows as body data appearing where only the unchanged prefix and zeros are expected. A wrong step counter shows as `done` arriving one or more edges away from VLMAX, which is checked on every command.

// File: rtl/slide_pkg.sv
// Shared types for the vector slide unit.
// Assumes elements are at most 64 bits wide.
package slide_pkg;
    localparam int ELEN = 64;

    typedef enum logic [1:0] {
        OP_UP    = 2'd0,
        OP_DOWN  = 2'd1,
        OP_UP1   = 2'd2,
        OP_DOWN1 = 2'd3
    } slide_op_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_SRC    = 2'd1,
        ACT_ZERO   = 2'd2,
        ACT_SCALAR = 2'd3
    } elem_act_e;

    // Low-order ones covering one element of the given width code.
    function automatic logic [ELEN-1:0] elem_mask(input logic [1:0] sew);
        case (sew)
            2'd0:    elem_mask = 64'h0000_0000_0000_00FF;
            2'd1:    elem_mask = 64'h0000_0000_0000_FFFF;
            2'd2:    elem_mask = 64'h0000_0000_FFFF_FFFF;
            default: elem_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/slide_vrf.sv
// Vector register file with a whole-register host port, one element
// write port and one element read port. Also exposes the low mask bits
// of register 0. Assumes VLEN >= 64 and VLEN a power of two.
module slide_vrf #(
    parameter int NREG = 8,
    parameter int VLEN = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_we,
    input  logic [$clog2(NREG)-1:0]  host_wreg,
    input  logic [VLEN-1:0]          host_wdata,
    input  logic [$clog2(NREG)-1:0]  host_rreg,
    output logic [VLEN-1:0]          host_rdata,
    input  logic                     el_we,
    input  logic [$clog2(NREG)-1:0]  el_reg,
    input  logic [$clog2(VLEN/8)-1:0] el_idx,
    input  logic [1:0]               el_sew,
    input  logic [slide_pkg::ELEN-1:0] el_data,
    input  logic [$clog2(NREG)-1:0]  src_reg,
    input  logic [$clog2(VLEN/8)-1:0] src_idx,
    output logic [slide_pkg::ELEN-1:0] src_data,
    output logic [VLEN/8-1:0]        v0_low
);
    import slide_pkg::*;

    localparam int RW   = $clog2(NREG);
    localparam int EMAX = VLEN / 8;
    localparam int IDXW = $clog2(EMAX);
    localparam int SHW  = IDXW + 3;

    logic [VLEN-1:0] regs [NREG];
    logic [SHW-1:0]  wr_sh, rd_sh;
    logic [ELEN-1:0] wr_wm;
    logic [VLEN-1:0] wr_field, wr_value, rd_shifted;

    // Bit offset and field mask for the element being written.
    always_comb begin
        wr_sh    = {el_idx, 3'b000} << el_sew;
        wr_wm    = elem_mask(el_sew);
        wr_field = VLEN'(wr_wm) << wr_sh;
        wr_value = VLEN'(el_data & wr_wm) << wr_sh;
    end

    // Element read: shift the selected element down and trim to its width.
    always_comb begin
        rd_sh      = {src_idx, 3'b000} << el_sew;
        rd_shifted = regs[src_reg] >> rd_sh;
        src_data   = rd_shifted[ELEN-1:0] & elem_mask(el_sew);
    end

    assign host_rdata = regs[host_rreg];
    assign v0_low     = regs[0][EMAX-1:0];

    // Storage update: reset clears, then host or element writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                regs[r] <= '0;
            end
        end else begin
            if (host_we) begin
                regs[host_wreg] <= host_wdata;
            end
            if (el_we) begin
                regs[el_reg] <= (regs[el_reg] & ~wr_field) | wr_value;
            end
        end
    end

    logic unused_rw;
    assign unused_rw = ^{RW{1'b0}};
endmodule

// File: rtl/slide_region.sv
// Classifies one element index into keep / source / zero / scalar and
// returns the source element index. Purely combinational.
// Assumes vl has already been clamped to vlmax.
module slide_region #(
    parameter int VLEN = 128,
    parameter int OFFW = 64
) (
    input  slide_pkg::slide_op_e      op,
    input  logic [$clog2(VLEN/8)-1:0]  idx,
    input  logic [$clog2(VLEN/8+1)-1:0] vstart,
    input  logic [$clog2(VLEN/8+1)-1:0] vl,
    input  logic [$clog2(VLEN/8+1)-1:0] vlmax,
    input  logic [OFFW-1:0]            offset,
    input  logic                       vm,
    input  logic                       mbit,
    output slide_pkg::elem_act_e       act,
    output logic [$clog2(VLEN/8)-1:0]  src_idx
);
    import slide_pkg::*;

    localparam int IDXW = $clog2(VLEN/8);
    localparam int XW   = OFFW + 1;

    logic [XW-1:0] ix, ox, sx, lx, mx, sum, diff;
    logic          active;

    // Widen all bounds so the offset is never truncated.
    always_comb begin
        ix     = XW'(idx);
        ox     = {1'b0, offset};
        sx     = XW'(vstart);
        lx     = XW'(vl);
        mx     = XW'(vlmax);
        sum    = ix + ox;
        diff   = ix - ox;
        active = vm | mbit;
    end

    // Region and source selection for the current element.
    always_comb begin
        act     = ACT_KEEP;
        src_idx = idx;
        if (ix >= lx) begin
            act = ACT_ZERO;
        end else if (ix >= sx && active) begin
            case (op)
                OP_UP: begin
                    if (ix >= ox) begin
                        act     = ACT_SRC;
                        src_idx = IDXW'(diff);
                    end
                end
                OP_UP1: begin
                    if (idx == '0) begin
                        act = ACT_SCALAR;
                    end else begin
                        act     = ACT_SRC;
                        src_idx = idx - IDXW'(1);
                    end
                end
                OP_DOWN: begin
                    if (sum < mx) begin
                        act     = ACT_SRC;
                        src_idx = IDXW'(sum);
                    end else begin
                        act = ACT_ZERO;
                    end
                end
                default: begin
                    if (ix == lx - XW'(1)) begin
                        act = ACT_SCALAR;
                    end else begin
                        act     = ACT_SRC;
                        src_idx = idx + IDXW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/slide_seq.sv
// Element walker: steps an index from 0 to the last element, one per
// cycle, and produces the done / illegal pulses. Commands that need no
// walk finish in the cycle after acceptance.
module slide_seq #(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            skip,
    input  logic            skip_bad,
    input  logic [IDXW-1:0] last_idx,
    output logic            busy,
    output logic [IDXW-1:0] idx,
    output logic            step,
    output logic            done,
    output logic            illegal
);
    logic [IDXW-1:0] last_q;

    // Walk state, index and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            last_q  <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            if (!busy) begin
                if (skip) begin
                    done    <= 1'b1;
                    illegal <= skip_bad;
                end else if (start) begin
                    busy   <= 1'b1;
                    idx    <= '0;
                    last_q <= last_idx;
                end
            end else if (idx == last_q) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                idx <= idx + IDXW'(1);
            end
        end
    end

    assign step = busy;
endmodule

// File: rtl/slide_unit.sv
// Top of the masked vector slide unit. Captures a command, snapshots the
// mask bits of register 0, then walks the destination one element per
// cycle. Assumes callers keep vstart and vl within the encodable range.
module slide_unit #(
    parameter int NREG = 8,
    parameter int VLEN = 128,
    parameter int OFFW = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [$clog2(NREG)-1:0]     host_wreg,
    input  logic [VLEN-1:0]             host_wdata,
    input  logic [$clog2(NREG)-1:0]     host_rreg,
    output logic [VLEN-1:0]             host_rdata,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [1:0]                  cmd_sew,
    input  logic [$clog2(NREG)-1:0]     cmd_vd,
    input  logic [$clog2(NREG)-1:0]     cmd_vs2,
    input  logic [OFFW-1:0]             cmd_offset,
    input  logic [63:0]                 cmd_scalar,
    input  logic                        cmd_vm,
    input  logic [$clog2(VLEN/8+1)-1:0] cmd_vstart,
    input  logic [$clog2(VLEN/8+1)-1:0] cmd_vl,
    output logic                        busy,
    output logic                        done,
    output logic                        illegal
);
    import slide_pkg::*;

    localparam int RW   = $clog2(NREG);
    localparam int EMAX = VLEN / 8;
    localparam int IDXW = $clog2(EMAX);
    localparam int LW   = $clog2(EMAX + 1);

    slide_op_e        op_in;
    logic             accept, cmd_bad, cmd_empty;
    logic [LW-1:0]    cmd_vlmax, cmd_vl_clamped;

    slide_op_e        r_op;
    logic [1:0]       r_sew;
    logic [RW-1:0]    r_vd, r_vs2;
    logic [OFFW-1:0]  r_off;
    logic [63:0]      r_scalar;
    logic             r_vm;
    logic [LW-1:0]    r_vstart, r_vl, r_vlmax;
    logic [EMAX-1:0]  r_mask, v0_low;

    logic [IDXW-1:0]  seq_idx, src_idx;
    logic             step;
    elem_act_e        act;
    logic [63:0]      src_data, el_data;
    logic             el_we;

    // Command decode: legality, empty length, element count.
    always_comb begin
        op_in          = slide_op_e'(cmd_op);
        accept         = cmd_valid && !busy;
        cmd_bad        = (op_in == OP_UP || op_in == OP_UP1) && (cmd_vd == cmd_vs2);
        cmd_empty      = (cmd_vl == '0);
        cmd_vlmax      = LW'(EMAX >> cmd_sew);
        cmd_vl_clamped = (cmd_vl > cmd_vlmax) ? cmd_vlmax : cmd_vl;
    end

    // Command capture on acceptance, including the mask snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_op     <= OP_UP;
            r_sew    <= '0;
            r_vd     <= '0;
            r_vs2    <= '0;
            r_off    <= '0;
            r_scalar <= '0;
            r_vm     <= 1'b0;
            r_vstart <= '0;
            r_vl     <= '0;
            r_vlmax  <= '0;
            r_mask   <= '0;
        end else if (accept) begin
            r_op     <= op_in;
            r_sew    <= cmd_sew;
            r_vd     <= cmd_vd;
            r_vs2    <= cmd_vs2;
            r_off    <= cmd_offset;
            r_scalar <= cmd_scalar;
            r_vm     <= cmd_vm;
            r_vstart <= cmd_vstart;
            r_vl     <= cmd_vl_clamped;
            r_vlmax  <= cmd_vlmax;
            r_mask   <= v0_low;
        end
    end

    slide_seq #(.IDXW(IDXW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && !cmd_bad && !cmd_empty),
        .skip     (accept && (cmd_bad || cmd_empty)),
        .skip_bad (cmd_bad),
        .last_idx (IDXW'(cmd_vlmax - LW'(1))),
        .busy     (busy),
        .idx      (seq_idx),
        .step     (step),
        .done     (done),
        .illegal  (illegal)
    );

    slide_region #(.VLEN(VLEN), .OFFW(OFFW)) u_region (
        .op      (r_op),
        .idx     (seq_idx),
        .vstart  (r_vstart),
        .vl      (r_vl),
        .vlmax   (r_vlmax),
        .offset  (r_off),
        .vm      (r_vm),
        .mbit    (r_mask[seq_idx]),
        .act     (act),
        .src_idx (src_idx)
    );

    // Element write value selected by the region decision.
    always_comb begin
        el_we = step && (act != ACT_KEEP);
        case (act)
            ACT_SRC:    el_data = src_data;
            ACT_SCALAR: el_data = r_scalar;
            default:    el_data = '0;
        endcase
    end

    slide_vrf #(.NREG(NREG), .VLEN(VLEN)) u_vrf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we && !busy),
        .host_wreg  (host_wreg),
        .host_wdata (host_wdata),
        .host_rreg  (host_rreg),
        .host_rdata (host_rdata),
        .el_we      (el_we),
        .el_reg     (r_vd),
        .el_idx     (seq_idx),
        .el_sew     (r_sew),
        .el_data    (el_data),
        .src_reg    (r_vs2),
        .src_idx    (src_idx),
        .src_data   (src_data),
        .v0_low     (v0_low)
    );
endmodule

// File: rtl/slide_unit_chk.sv
// Property checker for slide_unit, attached with bind below.
module slide_unit_chk #(
    parameter int VLEN = 128,
    parameter int OFFW = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cmd_valid,
    input logic [$clog2(VLEN/8+1)-1:0]   cmd_vl,
    input logic                          busy,
    input logic                          done,
    input logic                          illegal,
    input logic                          el_we,
    input logic [$clog2(VLEN/8)-1:0]     el_idx,
    input logic [63:0]                   el_data,
    input logic [1:0]                    r_op,
    input logic [OFFW-1:0]               r_off,
    input logic [$clog2(VLEN/8+1)-1:0]   r_vl
);
    localparam int LW = $clog2(VLEN/8 + 1);

    // R12: done is a single-cycle pulse when no new command follows.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cmd_valid |=> !done);

    // R12: element writes happen only during a walk.
    assert_write_in_walk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        el_we |-> busy);

    // R10: a rejection always comes with completion.
    assert_illegal_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done);

    // R6: an empty command completes at once without a walk.
    assert_empty_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_vl == '0 |=> done && !busy);

    // R4: tail writes carry zero.
    assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        el_we && LW'(el_idx) >= r_vl |-> el_data == 64'd0);

    // R5: slide-up never writes a body element below the full-width offset.
    assert_up_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        el_we && r_op == 2'd0 && LW'(el_idx) < r_vl |-> OFFW'(el_idx) >= r_off);
endmodule

bind slide_unit slide_unit_chk #(.VLEN(VLEN), .OFFW(OFFW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_vl    (cmd_vl),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .el_we     (el_we),
    .el_idx    (seq_idx),
    .el_data   (el_data),
    .r_op      (r_op),
    .r_off     (r_off),
    .r_vl      (r_vl)
);

// File: tb/slide_unit_test.sv
// Bench for slide_unit: directed corner cases plus seeded random commands,
// each compared against a register-file model written from the requirements.
module slide_unit_test;
    localparam int NREG = 8;
    localparam int VLEN = 128;
    localparam int OFFW = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_we = 1'b0;
    logic [2:0]      host_wreg = '0;
    logic [127:0]    host_wdata = '0;
    logic [2:0]      host_rreg = '0;
    logic [127:0]    host_rdata;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = '0;
    logic [1:0]      cmd_sew = '0;
    logic [2:0]      cmd_vd = '0;
    logic [2:0]      cmd_vs2 = '0;
    logic [63:0]     cmd_offset = '0;
    logic [63:0]     cmd_scalar = '0;
    logic            cmd_vm = 1'b0;
    logic [4:0]      cmd_vstart = '0;
    logic [4:0]      cmd_vl = '0;
    logic            busy, done, illegal;

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    logic [127:0] mreg [NREG];

    slide_unit #(.NREG(NREG), .VLEN(VLEN), .OFFW(OFFW)) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [63:0] wmask(input int sew);
        return (sew == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sew)) - 64'd1);
    endfunction

    function automatic logic [63:0] getel(input logic [127:0] v, input int i, input int sew);
        logic [127:0] t;
        t = v >> (i * (8 << sew));
        return t[63:0] & wmask(sew);
    endfunction

    function automatic logic [127:0] putel(input logic [127:0] v, input int i, input int sew,
                                           input logic [63:0] d);
        logic [127:0] f;
        f = {64'd0, wmask(sew)} << (i * (8 << sew));
        return (v & ~f) | ({64'd0, d & wmask(sew)} << (i * (8 << sew)));
    endfunction

    // Expected destination from the requirements.
    function automatic logic [127:0] model(input int op, input int sew, input logic [127:0] old,
        input logic [127:0] src, input logic [127:0] v0, input bit vm, input int vstart,
        input int vl, input logic [63:0] off, input logic [63:0] sc);
        logic [127:0] res;
        int vlmax;
        res = old;
        vlmax = 16 >> sew;
        if (vl > vlmax) vl = vlmax;
        if (vl == 0) return old;
        for (int i = 0; i < vlmax; i++) begin
            if (i >= vl) res = putel(res, i, sew, 64'd0);
            else if (i >= vstart && (vm || v0[i])) begin
                case (op)
                    0: if (off <= 64'(i)) res = putel(res, i, sew, getel(src, i - int'(off), sew));
                    1: if (off < 64'(vlmax) && off + 64'(i) < 64'(vlmax))
                           res = putel(res, i, sew, getel(src, i + int'(off), sew));
                       else res = putel(res, i, sew, 64'd0);
                    2: res = (i == 0) ? putel(res, i, sew, sc) : putel(res, i, sew, getel(src, i - 1, sew));
                    default: res = (i == vl - 1) ? putel(res, i, sew, sc)
                                                 : putel(res, i, sew, getel(src, i + 1, sew));
                endcase
            end
        end
        return res;
    endfunction

    task automatic check(input string tag, input string what, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic host_write(input int r, input logic [127:0] d);
        @(negedge clk);
        host_we = 1'b1; host_wreg = 3'(r); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        mreg[r] = d;
    endtask

    task automatic check_all_regs(input string tag);
        logic [127:0] rd;
        int bad;
        bad = 0;
        for (int r = 0; r < NREG; r++) begin
            host_rreg = 3'(r);
            #1;
            rd = host_rdata;
            if (rd !== mreg[r]) begin
                bad++;
                check(tag, $sformatf("reg%0d", r), rd, mreg[r]);
            end
        end
        if (bad == 0) check(tag, "regfile", 128'd0, 128'd0);
    endtask

    task automatic run_cmd(input string tag, input int op, input int sew, input int vd,
        input int vs2, input logic [63:0] off, input logic [63:0] sc, input bit vm,
        input int vstart, input int vl);
        logic [127:0] exp;
        bit bad;
        int n, vlmax, explat;
        vlmax = 16 >> sew;
        bad = (op == 0 || op == 2) && (vd == vs2);
        exp = bad ? mreg[vd] : model(op, sew, mreg[vd], mreg[vs2], mreg[0], vm, vstart, vl, off, sc);
        explat = (bad || vl == 0) ? 0 : vlmax;
        @(negedge clk);
        cmd_op = 2'(op); cmd_sew = 2'(sew); cmd_vd = 3'(vd); cmd_vs2 = 3'(vs2);
        cmd_offset = off; cmd_scalar = sc; cmd_vm = vm; cmd_vstart = 5'(vstart); cmd_vl = 5'(vl);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        check("R12", "done latency", 128'(n), 128'(explat));
        check(bad ? "R10" : tag, "illegal flag", 128'(illegal), 128'(bad));
        @(negedge clk);
        check("R12", "done pulse width", 128'(done), 128'd0);
        mreg[vd] = exp;
        check_all_regs(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R12 watchdog: actual=hung expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20507);
        for (int r = 0; r < NREG; r++) mreg[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", 128'(busy), 128'd0);
        check("R1", "done", 128'(done), 128'd0);
        check("R1", "illegal", 128'(illegal), 128'd0);
        check_all_regs("R1");

        for (int r = 0; r < NREG; r++) host_write(r, rnd128());

        // R2 R4: plain slide-up, 8-bit, tail zeroed
        run_cmd("R2", 0, 0, 2, 3, 64'd3, 64'd0, 1'b1, 0, 12);
        // R5: upper offset bits set, low bits look like 2
        run_cmd("R5", 0, 0, 4, 5, 64'h1_0000_0002, 64'd0, 1'b1, 0, 10);
        // R5: offset beyond vl, no body
        run_cmd("R5", 0, 0, 6, 1, 64'd20, 64'd0, 1'b1, 0, 9);
        // R6: empty length
        run_cmd("R6", 1, 1, 3, 4, 64'd1, 64'd0, 1'b1, 0, 0);
        // R10: in-place slide-1-up rejected
        run_cmd("R10", 2, 0, 5, 5, 64'd0, 64'h55, 1'b1, 0, 8);
        // R7: slide-down past VLMAX, 16-bit
        run_cmd("R7", 1, 1, 2, 7, 64'd5, 64'd0, 1'b1, 0, 8);
        // R7: huge offset must not wrap
        run_cmd("R7", 1, 2, 3, 6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 0, 4);
        // R8 R3: element 0 masked off
        host_write(0, {rnd128() & ~128'd1});
        run_cmd("R8", 2, 0, 4, 2, 64'd0, 64'hA5, 1'b0, 0, 16);
        // R9 R3: element vl-1 active
        host_write(0, 128'h0000_0000_0000_0000_0000_0000_0000_0020);
        run_cmd("R9", 3, 0, 6, 3, 64'd0, 64'h3C, 1'b0, 0, 6);
        // R11: 64-bit elements, vstart 1
        run_cmd("R11", 0, 3, 1, 7, 64'd0, 64'd0, 1'b1, 1, 2);
        // R3: masked slide-up with vstart
        host_write(0, 128'h0000_0000_0000_0000_0000_0000_0000_5A5A);
        run_cmd("R3", 0, 0, 7, 2, 64'd1, 64'd0, 1'b0, 2, 14);

        for (int k = 0; k < 70; k++) begin
            int op, sew, vd, vs2, vlmax, vl, vs;
            logic [63:0] off;
            string tag;
            op = $urandom % 4; sew = $urandom % 4; vlmax = 16 >> sew;
            vd = $urandom % 8; vs2 = $urandom % 8;
            if ((op == 0 || op == 2) && vd == vs2 && ($urandom % 4 != 0)) vs2 = (vd + 1) % 8;
            vl = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % vlmax);
            vs = ($urandom % 3 == 0) ? ($urandom % (vlmax + 1)) : 0;
            off = ($urandom % 6 == 0) ? {$urandom, $urandom} : 64'($urandom % (vlmax + 3));
            if ($urandom % 3 == 0) host_write($urandom % 8, rnd128());
            case (op)
                0: tag = "R2";
                1: tag = "R7";
                2: tag = "R8";
                default: tag = "R9";
            endcase
            run_cmd(tag, op, sew, vd, vs2, off, {$urandom, $urandom}, 1'($urandom % 2), vs, vl);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule